// File: doc/BRIEF.md
# Region-Mapped Address Translation Unit

This block turns a 32-bit virtual address into a physical address. A small set of variable-sized region windows is searched first. Each window covers a power-of-two span from 64 KB up to 2 GB. An address that no valid window covers goes to a 64-entry direct-indexed translation lookaside buffer (TLB) with a fixed 4 KB page. A valid entry whose tag matches supplies the physical page number.

Software programs the windows and the TLB through one word-wide register port. Each window and each TLB entry uses two 32-bit words. All writes on this port need the supervisor flag. A requester presents a virtual address, a supervisor/user flag and a read/write flag. One clock later it gets exactly one of three results: a translation (hit), a miss, or a protection fault. Refills after a miss are left to the software.

Top module: `xlat_unit`

## Requirements
- R1: After reset, every window and every TLB word reads back as zero, and a lookup reports a miss.
- R2: Register port map. cfg_addr[7]=0 selects window cfg_addr[6:1], and cfg_addr[7]=1 selects TLB entry cfg_addr[6:1]. cfg_addr[0] picks the first word (0) or the second word (1). cfg_rdata returns the selected word combinationally.
- R3: A write with cfg_sup=0 leaves every window and TLB word unchanged.
- R4: Window first word layout: virtual base in [31:16], valid in [8], supervisor read in [9], supervisor write in [10], user read in [11], user write in [12], and size code s in [3:0]. The size code gives a span of 2^(16+s) bytes. The second word holds the physical base in [31:16]. On a match, the address bits at and above bit 16+s come from the physical base and the lower bits pass through unchanged.
- R5: A matching valid window takes priority over the TLB. When two windows match, the lower-numbered window wins.
- R6: The TLB is indexed by va[17:12]. The first word holds the tag in [31:18] and uses the same valid and permission bits as a window. The second word holds the page number in [31:12]. On a hit the result is {page number, va[11:0]}.
- R7: When no window and no TLB entry match, the lookup reports a miss and lk_pa is zero.
- R8: A matching window or entry whose permission bit for the access kind (supervisor or user, read or write) is clear gives a fault with lk_pa zero. It does not fall through to the TLB.
- R9: The result appears on the clock edge that samples lk_req. When lk_ack is high, exactly one of hit, miss and fault is high. When lk_ack is low, all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sup | input | 1 | Writer is supervisor |
| cfg_addr | input | 8 | Register select |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of selected register |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address |
| lk_sup | input | 1 | Access is supervisor |
| lk_wr | input | 1 | Access is a write |
| lk_ack | output | 1 | Result valid |
| lk_pa | output | 32 | Physical address |
| lk_hit | output | 1 | Translation found and permitted |
| lk_miss | output | 1 | No window or entry matched |
| lk_fault | output | 1 | Match found but access not permitted |

## Verification
Every stored word can be read back directly, so a corrupted window or TLB word shows up on cfg_rdata as soon as it is selected. It also shows up on the next lookup that touches that word. A wrong mask in the size decode shows one of two symptoms one cycle after the request: a wrong upper address field, or a miss where a hit was due (or the reverse). The bench sweeps all sixteen size codes and fills all 64 TLB entries, so a fault in any mask bit or index line reaches lk_pa or the result flags. A broken priority chain or a broken permission decode returns the wrong physical base, or a fault where a hit was due, on the very next lookup.

// File: rtl/xlat_unit.sv
module xlat_unit #(
  parameter int TLB_ENTRIES = 64,
  parameter int PAGE_BITS   = 12,
  parameter int NREG        = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cfg_sup,
  input  logic [7:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        lk_req,
  input  logic [31:0] lk_va,
  input  logic        lk_sup,
  input  logic        lk_wr,
  output logic        lk_ack,
  output logic [31:0] lk_pa,
  output logic        lk_hit,
  output logic        lk_miss,
  output logic        lk_fault
);
  localparam int IDX_W = $clog2(TLB_ENTRIES);
  localparam int TAG_W = 32 - PAGE_BITS - IDX_W;
  localparam int PPN_W = 32 - PAGE_BITS;
  localparam int RI_W  = (NREG > 1) ? $clog2(NREG) : 1;

  logic [31:0] rg_lo [NREG];
  logic [31:0] rg_hi [NREG];
  logic [31:0] tl_lo [TLB_ENTRIES];
  logic [31:0] tl_hi [TLB_ENTRIES];

  wire [IDX_W-1:0] c_tidx = cfg_addr[IDX_W:1];
  wire [RI_W-1:0]  c_ridx = cfg_addr[RI_W:1];
  wire             c_rok  = ({2'b0, cfg_addr[6:1]} < 8'(NREG));

  function automatic logic perm_ok(input logic [31:0] w, input logic sup, input logic wr);
    return sup ? (wr ? w[10] : w[9]) : (wr ? w[12] : w[11]);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        rg_lo[i] <= '0;
        rg_hi[i] <= '0;
      end
      for (int i = 0; i < TLB_ENTRIES; i++) begin
        tl_lo[i] <= '0;
        tl_hi[i] <= '0;
      end
    end else if (cfg_we && cfg_sup) begin
      if (cfg_addr[7]) begin
        if (cfg_addr[0]) tl_hi[c_tidx] <= cfg_wdata;
        else             tl_lo[c_tidx] <= cfg_wdata;
      end else if (c_rok) begin
        if (cfg_addr[0]) rg_hi[c_ridx] <= cfg_wdata;
        else             rg_lo[c_ridx] <= cfg_wdata;
      end
    end
  end

  always_comb begin
    if (cfg_addr[7])
      cfg_rdata = cfg_addr[0] ? tl_hi[c_tidx] : tl_lo[c_tidx];
    else if (c_rok)
      cfg_rdata = cfg_addr[0] ? rg_hi[c_ridx] : rg_lo[c_ridx];
    else
      cfg_rdata = '0;
  end

  logic        r_hit;
  logic [31:0] r_word, r_pa;
  logic [15:0] rmask;

  always_comb begin
    r_hit  = 1'b0;
    r_word = '0;
    r_pa   = '0;
    rmask  = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      rmask = 16'hFFFF << rg_lo[i][3:0];
      if (rg_lo[i][8] && (((lk_va[31:16] ^ rg_lo[i][31:16]) & rmask) == 16'h0)) begin
        r_hit  = 1'b1;
        r_word = rg_lo[i];
        r_pa   = {(rg_hi[i][31:16] & rmask) | (lk_va[31:16] & ~rmask), lk_va[15:0]};
      end
    end
  end

  wire [IDX_W-1:0] t_idx  = lk_va[PAGE_BITS +: IDX_W];
  wire [31:0]      t_word = tl_lo[t_idx];
  wire             t_hit  = t_word[8] && (t_word[31 -: TAG_W] == lk_va[31 -: TAG_W]);
  wire [31:0]      t_pa   = {tl_hi[t_idx][31 -: PPN_W], lk_va[PAGE_BITS-1:0]};

  wire        any_hit = r_hit | t_hit;
  wire        ok      = perm_ok(r_hit ? r_word : t_word, lk_sup, lk_wr);
  wire [31:0] sel_pa  = r_hit ? r_pa : t_pa;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_ack   <= 1'b0;
      lk_hit   <= 1'b0;
      lk_miss  <= 1'b0;
      lk_fault <= 1'b0;
      lk_pa    <= '0;
    end else begin
      lk_ack   <= lk_req;
      lk_hit   <= lk_req & any_hit & ok;
      lk_miss  <= lk_req & ~any_hit;
      lk_fault <= lk_req & any_hit & ~ok;
      lk_pa    <= (lk_req & any_hit & ok) ? sel_pa : '0;
    end
  end

  a_r9_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> lk_ack);
  a_r9_one_result: assert property (@(posedge clk) disable iff (!rst_n)
    lk_ack |-> $onehot({lk_hit, lk_miss, lk_fault}));
  a_r9_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_ack |-> (!lk_hit && !lk_miss && !lk_fault && lk_pa == 32'h0));
  a_r3_user_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_sup && !cfg_addr[7] && cfg_addr[6:1] == 6'd0) |=> ($stable(rg_lo[0]) && $stable(rg_hi[0])));
  a_r4_low_bits_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && r_hit) |=> (lk_fault || lk_pa[15:0] == $past(lk_va[15:0])));
  a_r6_page_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && !r_hit && t_hit) |=> (lk_fault || lk_pa[PAGE_BITS-1:0] == $past(lk_va[PAGE_BITS-1:0])));
  a_r7_miss_zero_pa: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> lk_pa == 32'h0);
endmodule

// File: tb/xlat_unit_tb.sv
module xlat_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] HIT = 3'b100, MISS = 3'b010, FLT = 3'b001;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_sup = 1;
  logic [7:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic lk_req = 0, lk_sup = 0, lk_wr = 0;
  logic [31:0] lk_va = 0, lk_pa;
  logic lk_ack, lk_hit, lk_miss, lk_fault;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_unit dut_i (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic s);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d; cfg_sup = s;
    @(negedge clk);
    cfg_we = 0; cfg_sup = 1;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1 check(tag, cfg_rdata, exp);
  endtask

  task automatic look(input string tag, input logic [31:0] va, input logic s, input logic w,
                      input logic [2:0] flags, input logic [31:0] pa);
    @(negedge clk);
    lk_req = 1; lk_va = va; lk_sup = s; lk_wr = w;
    @(negedge clk);
    lk_req = 0;
    check({tag, " flags"}, {29'b0, lk_hit, lk_miss, lk_fault}, {29'b0, flags});
    check({tag, " pa"}, lk_pa, pa);
    check({tag, " ack"}, {31'b0, lk_ack}, 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] vb, pb, mask, va_in, pa_in;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 idle outputs", {28'b0, lk_ack, lk_hit, lk_miss, lk_fault}, 32'h0);
    rd("R1 window word", 8'h00, 32'h0);
    rd("R1 tlb word", 8'h8B, 32'h0);
    look("R1 lookup", 32'h1234_5678, 1, 0, MISS, 32'h0);

    // R4 size sweep on window 0
    vb = 32'hA5C3_0000; pb = 32'h3C5A_0000;
    for (int s = 0; s < 16; s++) begin
      wr(8'h00, vb | 32'h1F00 | s, 1);
      wr(8'h01, pb, 1);
      mask  = 32'hFFFF_FFFF << (16 + s);
      va_in = (vb & mask) | (32'h5E6F_7A8B & ~mask);
      pa_in = (pb & mask) | (va_in & ~mask);
      look($sformatf("R4 size %0d inside", s), va_in, s[0], s[1], HIT, pa_in);
      look($sformatf("R7 size %0d outside", s), va_in ^ (32'h1 << (16 + s)), 1, 0, MISS, 32'h0);
    end

    // R2 readback
    rd("R2 window0 lo", 8'h00, vb | 32'h1F0F);
    rd("R2 window0 hi", 8'h01, pb);

    // R5 priority: TLB entry 5 then windows over it
    wr(8'h00, 32'h0, 1);
    wr(8'h8A, (32'h48D << 18) | 32'h1F00, 1);
    wr(8'h8B, 32'hCAFE_B000, 1);
    rd("R2 tlb5 hi", 8'h8B, 32'hCAFE_B000);
    look("R6 tlb hit", 32'h1234_5678, 0, 1, HIT, 32'hCAFE_B678);
    wr(8'h02, 32'h1230_1F04, 1);
    wr(8'h03, 32'h8000_0000, 1);
    look("R5 window over tlb", 32'h1234_5678, 0, 0, HIT, 32'h8004_5678);
    wr(8'h00, 32'h1230_1F04, 1);
    wr(8'h01, 32'h4000_0000, 1);
    look("R5 lower window wins", 32'h1234_5678, 1, 1, HIT, 32'h4004_5678);

    // R3 unprivileged writes ignored
    wr(8'h01, 32'hDEAD_0000, 0);
    rd("R3 window word kept", 8'h01, 32'h4000_0000);
    look("R3 window mapping kept", 32'h1234_5678, 1, 0, HIT, 32'h4004_5678);
    wr(8'h8B, 32'h1111_1000, 0);
    rd("R3 tlb word kept", 8'h8B, 32'hCAFE_B000);

    // R8 permissions on window 0
    wr(8'h00, 32'h1230_0304, 1);
    look("R8 sup read ok", 32'h1234_5678, 1, 0, HIT, 32'h4004_5678);
    look("R8 sup write fault", 32'h1234_5678, 1, 1, FLT, 32'h0);
    look("R8 user read fault", 32'h1234_5678, 0, 0, FLT, 32'h0);
    wr(8'h00, 32'h1230_1104, 1);
    look("R8 user write ok", 32'h1234_5678, 0, 1, HIT, 32'h4004_5678);
    look("R8 user read fault", 32'h1234_5678, 0, 0, FLT, 32'h0);
    wr(8'h00, 32'h0, 1);
    look("R5 unit1 after unit0 off", 32'h1234_5678, 1, 0, HIT, 32'h8004_5678);
    wr(8'h02, 32'h0, 1);
    wr(8'h8A, (32'h48D << 18) | 32'h0900, 1);
    look("R8 tlb user read ok", 32'h1234_5678, 0, 0, HIT, 32'hCAFE_B678);
    look("R8 tlb sup read fault", 32'h1234_5678, 1, 0, FLT, 32'h0);

    // R6 full TLB sweep
    for (int i = 0; i < 64; i++) begin
      wr(8'h80 | 8'(i << 1), ((32'(i * 37 + 5) & 32'h3FFF) << 18) | 32'h1F00, 1);
      wr(8'h81 | 8'(i << 1), (32'hA0000 + 32'(i * 3)) << 12, 1);
    end
    for (int i = 0; i < 64; i++) begin
      logic [31:0] va;
      va = ((32'(i * 37 + 5) & 32'h3FFF) << 18) | (32'(i) << 12) | (32'(i * 61) & 32'hFFF);
      look($sformatf("R6 entry %0d", i), va, i[0], i[1], HIT,
           ((32'hA0000 + 32'(i * 3)) << 12) | (va & 32'hFFF));
      look($sformatf("R7 entry %0d tag", i), va ^ 32'h0004_0000, 1, 0, MISS, 32'h0);
    end

    @(negedge clk);
    check("R9 idle after lookup", {28'b0, lk_ack, lk_hit, lk_miss, lk_fault}, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule